// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer whose write side and read side each run on their own clock. The depth is a parameter. Words are stored in a two-port array, which block RAM can hold, and are returned in the order they were written. A write needs both write enables asserted, and a read needs both read enables asserted. This lets two control sources gate each port, or lets one enable be tied active.

Four active-low status outputs report the fill state. Empty and almost-empty are produced in the read domain. Full and almost-full are produced in the write domain. Each side works out its own view of the unread-word count. It does this by taking the other side's pointer, carried across in Gray code through a two-flop synchroniser. The almost-empty threshold and the almost-full threshold are inputs, held steady by a neighbouring offset block. When the buffer is at its limits, the empty and full flags block the operation that would underflow or overflow it.

Top module: `dcfifo_pflags`

## Requirements
- R1: `empty_n` is LOW whenever the read side's view of the unread-word count is zero, and while it is LOW no read takes place: the read pointer and `rdata` stay unchanged whatever the read enables do.
- R2: Words leave in the order they were written. A read registered on a rising `rclk` edge presents its word on `rdata` after that same edge, and `rdata` holds its value across cycles with no read.
- R3: `full_n` is LOW when the write side's view of the unread-word count equals DEPTH, and while it is LOW no write takes place, so no stored word is overwritten.
- R4: `aempty_n` is LOW when the read side's unread count is `thr_empty` or less, and HIGH when it is `thr_empty`+1 or more. It follows the count through one extra `rclk` flip-flop stage, so it lags `empty_n` by one read edge.
- R5: `afull_n` is LOW when the write side's unread count plus `thr_full` is at least DEPTH, and HIGH otherwise. It follows the count through one extra `wclk` flip-flop stage.
- R6: A write happens only when `wen_a` and `wen_b` are both 1 on a `wclk` edge. A read happens only when `ren_a` and `ren_b` are both 1 on an `rclk` edge. Either enable alone has no effect.
- R7: While the resets are held, both pointers are zero, `empty_n` = 0, `aempty_n` = 0, `full_n` = 1 and `afull_n` = 1.
- R8: Each pointer moves by at most one Gray-code bit per edge. A write becomes visible to the read side (`empty_n` rises) on the third `rclk` edge after the write edge, when the clocks are the same.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-domain clock |
| wrst | input | 1 | Synchronous active-high reset, write domain |
| wen_a | input | 1 | First write enable |
| wen_b | input | 1 | Second write enable |
| wdata | input | DATA_W | Word to store |
| rclk | input | 1 | Read-domain clock |
| rrst | input | 1 | Synchronous active-high reset, read domain |
| ren_a | input | 1 | First read enable |
| ren_b | input | 1 | Second read enable |
| rdata | output | DATA_W | Registered read word |
| thr_empty | input | ADDR_W+1 | Almost-empty threshold n |
| thr_full | input | ADDR_W+1 | Almost-full threshold m |
| empty_n | output | 1 | Empty flag, active low, read domain |
| full_n | output | 1 | Full flag, active low, write domain |
| aempty_n | output | 1 | Almost-empty flag, active low, read domain |
| afull_n | output | 1 | Almost-full flag, active low, write domain |

## Verification
Some properties are checked on every edge by the assertions. A pointer stays frozen while its port is blocked by a flag or by a missing enable. Neither side's count ever leaves the range zero to DEPTH. The Gray pointers change by at most one bit per edge. `rdata` holds when no read happens. Other behaviour can only be shown by the bench's scenarios, which compare against a reference queue: the exact edge on which each flag moves, the extra stage on the two threshold flags, the three-edge crossing latency, and the ordering of the words that come out.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/fifo_sync.sv
module fifo_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/fifo_ram.sv
module fifo_ram #(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              rrst,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (rrst)    rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fifo_wr_ctl.sv
module fifo_wr_ctl
  import dcfifo_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int PW = ADDR_W + 1
) (
  input  logic              wclk,
  input  logic              wrst,
  input  logic              wen_a,
  input  logic              wen_b,
  input  logic [PW-1:0]     rgray_sync,
  input  logic [PW-1:0]     thr_full,
  output logic              wr_fire,
  output logic [ADDR_W-1:0] waddr,
  output logic [PW-1:0]     wbin,
  output logic [PW-1:0]     wgray,
  output logic              full_n,
  output logic              afull_n
);
  localparam logic [PW-1:0] DEPTH_P = PW'(1 << ADDR_W);
  localparam logic [PW:0]   DEPTH_X = (PW+1)'(1 << ADDR_W);

  logic [PW-1:0] rbin_s, wbin_nx, wcnt_nx;
  logic          af_stage;

  assign rbin_s  = PW'(gray2bin(32'(rgray_sync)));
  assign wr_fire = wen_a & wen_b & full_n;
  assign wbin_nx = wbin + {{(PW-1){1'b0}}, wr_fire};
  assign wcnt_nx = wbin_nx - rbin_s;
  assign waddr   = wbin[ADDR_W-1:0];

  always_ff @(posedge wclk) begin
    if (wrst) begin
      wbin     <= '0;
      wgray    <= '0;
      full_n   <= 1'b1;
      af_stage <= 1'b0;
      afull_n  <= 1'b1;
    end else begin
      wbin     <= wbin_nx;
      wgray    <= PW'(bin2gray(32'(wbin_nx)));
      full_n   <= (wcnt_nx != DEPTH_P);
      af_stage <= (({1'b0, wcnt_nx} + {1'b0, thr_full}) >= DEPTH_X);
      afull_n  <= !af_stage;
    end
  end
endmodule

// File: rtl/fifo_rd_ctl.sv
module fifo_rd_ctl
  import dcfifo_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int PW = ADDR_W + 1
) (
  input  logic              rclk,
  input  logic              rrst,
  input  logic              ren_a,
  input  logic              ren_b,
  input  logic [PW-1:0]     wgray_sync,
  input  logic [PW-1:0]     thr_empty,
  output logic              rd_fire,
  output logic [ADDR_W-1:0] raddr,
  output logic [PW-1:0]     rbin,
  output logic [PW-1:0]     rgray,
  output logic              empty_n,
  output logic              aempty_n
);
  logic [PW-1:0] wbin_s, rbin_nx, rcnt_nx;
  logic          ae_stage;

  assign wbin_s  = PW'(gray2bin(32'(wgray_sync)));
  assign rd_fire = ren_a & ren_b & empty_n;
  assign rbin_nx = rbin + {{(PW-1){1'b0}}, rd_fire};
  assign rcnt_nx = wbin_s - rbin_nx;
  assign raddr   = rbin[ADDR_W-1:0];

  always_ff @(posedge rclk) begin
    if (rrst) begin
      rbin     <= '0;
      rgray    <= '0;
      empty_n  <= 1'b0;
      ae_stage <= 1'b1;
      aempty_n <= 1'b0;
    end else begin
      rbin     <= rbin_nx;
      rgray    <= PW'(bin2gray(32'(rbin_nx)));
      empty_n  <= (rcnt_nx != '0);
      ae_stage <= (rcnt_nx <= thr_empty);
      aempty_n <= !ae_stage;
    end
  end
endmodule

// File: rtl/dcfifo_pflags.sv
module dcfifo_pflags #(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 4
) (
  input  logic              wclk,
  input  logic              wrst,
  input  logic              wen_a,
  input  logic              wen_b,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              rrst,
  input  logic              ren_a,
  input  logic              ren_b,
  output logic [DATA_W-1:0] rdata,
  input  logic [ADDR_W:0]   thr_empty,
  input  logic [ADDR_W:0]   thr_full,
  output logic              empty_n,
  output logic              full_n,
  output logic              aempty_n,
  output logic              afull_n
);
  localparam int PW = ADDR_W + 1;

  logic              wr_fire, rd_fire;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [PW-1:0]     wbin, wgray, rbin, rgray;
  logic [PW-1:0]     wgray_r, rgray_w;

  fifo_wr_ctl #(.ADDR_W(ADDR_W)) u_wr (
    .wclk(wclk), .wrst(wrst), .wen_a(wen_a), .wen_b(wen_b),
    .rgray_sync(rgray_w), .thr_full(thr_full),
    .wr_fire(wr_fire), .waddr(waddr), .wbin(wbin), .wgray(wgray),
    .full_n(full_n), .afull_n(afull_n)
  );

  fifo_rd_ctl #(.ADDR_W(ADDR_W)) u_rd (
    .rclk(rclk), .rrst(rrst), .ren_a(ren_a), .ren_b(ren_b),
    .wgray_sync(wgray_r), .thr_empty(thr_empty),
    .rd_fire(rd_fire), .raddr(raddr), .rbin(rbin), .rgray(rgray),
    .empty_n(empty_n), .aempty_n(aempty_n)
  );

  fifo_sync #(.W(PW)) u_w2r (.clk(rclk), .rst(rrst), .d(wgray), .q(wgray_r));
  fifo_sync #(.W(PW)) u_r2w (.clk(wclk), .rst(wrst), .d(rgray), .q(rgray_w));

  fifo_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .wclk(wclk), .we(wr_fire), .waddr(waddr), .wdata(wdata),
    .rclk(rclk), .rrst(rrst), .re(rd_fire), .raddr(raddr), .rdata(rdata)
  );
endmodule

// File: rtl/dcfifo_pflags_chk.sv
module dcfifo_pflags_chk
  import dcfifo_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 4,
  localparam int PW = ADDR_W + 1
) (
  input logic              wclk,
  input logic              wrst,
  input logic              rclk,
  input logic              rrst,
  input logic              wen_a,
  input logic              wen_b,
  input logic              ren_a,
  input logic              ren_b,
  input logic              empty_n,
  input logic              full_n,
  input logic [DATA_W-1:0] rdata,
  input logic [PW-1:0]     wbin,
  input logic [PW-1:0]     rbin,
  input logic [PW-1:0]     wgray,
  input logic [PW-1:0]     rgray,
  input logic [PW-1:0]     wgray_r,
  input logic [PW-1:0]     rgray_w
);
  localparam logic [PW-1:0] DEPTH_P = PW'(1 << ADDR_W);

  logic [PW-1:0] rbin_seen_w, wbin_seen_r;
  assign rbin_seen_w = PW'(gray2bin(32'(rgray_w)));
  assign wbin_seen_r = PW'(gray2bin(32'(wgray_r)));

  p_no_overflow_r3: assert property (@(posedge wclk) disable iff (wrst)
    (PW'(wbin - rbin_seen_w) <= DEPTH_P));

  p_blocked_when_full_r3: assert property (@(posedge wclk) disable iff (wrst)
    !full_n |=> $stable(wbin));

  p_no_underflow_r1: assert property (@(posedge rclk) disable iff (rrst)
    (PW'(wbin_seen_r - rbin) <= DEPTH_P));

  p_blocked_when_empty_r1: assert property (@(posedge rclk) disable iff (rrst)
    !empty_n |=> $stable(rbin));

  p_write_needs_both_r6: assert property (@(posedge wclk) disable iff (wrst)
    !(wen_a && wen_b) |=> $stable(wbin));

  p_read_needs_both_r6: assert property (@(posedge rclk) disable iff (rrst)
    !(ren_a && ren_b) |=> $stable(rbin));

  p_rdata_holds_r2: assert property (@(posedge rclk) disable iff (rrst)
    !(ren_a && ren_b && empty_n) |=> $stable(rdata));

  p_wgray_step_r8: assert property (@(posedge wclk) disable iff (wrst)
    $countones(wgray ^ $past(wgray)) <= 1);

  p_rgray_step_r8: assert property (@(posedge rclk) disable iff (rrst)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

bind dcfifo_pflags dcfifo_pflags_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .wclk(wclk), .wrst(wrst), .rclk(rclk), .rrst(rrst),
  .wen_a(wen_a), .wen_b(wen_b), .ren_a(ren_a), .ren_b(ren_b),
  .empty_n(empty_n), .full_n(full_n), .rdata(rdata),
  .wbin(wbin), .rbin(rbin), .wgray(wgray), .rgray(rgray),
  .wgray_r(wgray_r), .rgray_w(rgray_w)
);

// File: tb/tb_dcfifo_pflags.sv
`timescale 1ns/1ps
module tb_dcfifo_pflags;
  localparam int DW = 9;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst;
  logic          wen_a, wen_b, ren_a, ren_b;
  logic [DW-1:0] wdata, rdata;
  logic [AW:0]   thr_empty, thr_full;
  logic          empty_n, full_n, aempty_n, afull_n;

  dcfifo_pflags #(.DATA_W(DW), .ADDR_W(AW)) dut (
    .wclk(clk), .wrst(rst), .wen_a(wen_a), .wen_b(wen_b), .wdata(wdata),
    .rclk(clk), .rrst(rst), .ren_a(ren_a), .ren_b(ren_b), .rdata(rdata),
    .thr_empty(thr_empty), .thr_full(thr_full),
    .empty_n(empty_n), .full_n(full_n), .aempty_n(aempty_n), .afull_n(afull_n)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state
  int wp, rp;
  int wh[3];
  int rh[3];
  bit m_empty_n, m_full_n, m_ae_n, m_af_n, m_ae_st, m_af_st;
  logic [DW-1:0] m_rdata;
  logic [DW-1:0] q[$];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    wp = 0; rp = 0;
    for (int i = 0; i < 3; i++) begin wh[i] = 0; rh[i] = 0; end
    m_empty_n = 0; m_ae_st = 1; m_ae_n = 0;
    m_full_n = 1; m_af_st = 0; m_af_n = 1;
    m_rdata = '0;
    q.delete();
  endtask

  task automatic compare();
    chk("R1 empty_n", int'(empty_n), int'(m_empty_n));
    chk("R3 full_n", int'(full_n), int'(m_full_n));
    chk("R4 aempty_n", int'(aempty_n), int'(m_ae_n));
    chk("R5 afull_n", int'(afull_n), int'(m_af_n));
    chk("R2 rdata", int'(rdata), int'(m_rdata));
  endtask

  // one clock: predict the edge from current inputs, then sample at negedge
  task automatic step();
    bit we, re;
    int wpn, rpn, rc, wc;
    we = wen_a && wen_b && m_full_n;
    re = ren_a && ren_b && m_empty_n;
    wpn = wp + int'(we);
    rpn = rp + int'(re);
    if (re) m_rdata = q.pop_front();
    if (we) q.push_back(wdata);
    rc = wh[2] - rpn;
    wc = wpn - rh[2];
    m_ae_n = !m_ae_st;
    m_ae_st = (rc <= int'(thr_empty));
    m_empty_n = (rc != 0);
    m_af_n = !m_af_st;
    m_af_st = ((wc + int'(thr_full)) >= DEPTH);
    m_full_n = (wc != DEPTH);
    wh[2] = wh[1]; wh[1] = wh[0]; wh[0] = wpn;
    rh[2] = rh[1]; rh[1] = rh[0]; rh[0] = rpn;
    wp = wpn; rp = rpn;
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    wen_a = 0; wen_b = 0; ren_a = 0; ren_b = 0;
  endtask

  initial begin
    rst = 1; idle(); wdata = '0;
    thr_empty = 5'd2; thr_full = 5'd3;
    repeat (3) @(negedge clk);
    // R7: reset state
    chk("R7 empty_n reset", int'(empty_n), 0);
    chk("R7 aempty_n reset", int'(aempty_n), 0);
    chk("R7 full_n reset", int'(full_n), 1);
    chk("R7 afull_n reset", int'(afull_n), 1);
    rst = 0;
    model_reset();

    // R6: single enables do nothing
    wdata = 9'h0AA;
    wen_a = 1; wen_b = 0; ren_a = 1; ren_b = 0;
    repeat (4) step();
    wen_a = 0; wen_b = 1; ren_a = 0; ren_b = 1;
    repeat (4) step();
    idle();
    repeat (4) step();
    chk("R6 no write with one enable", int'(empty_n), 0);

    // R8: crossing latency of one write
    begin
      int k;
      wdata = 9'h155; wen_a = 1; wen_b = 1;
      step();
      idle();
      k = 0;
      while (!empty_n && k < 10) begin step(); k++; end
      chk("R8 write visible after edges", k, 3);
    end
    ren_a = 1; ren_b = 1;
    step();
    idle();
    step();
    chk("R2 first word out", int'(rdata), 'h155);

    // R3: overfill, then drain and count words
    for (int i = 0; i < 24; i++) begin
      wen_a = 1; wen_b = 1; wdata = DW'(9'h100 + i);
      step();
    end
    idle();
    chk("R3 full held after overfill", int'(full_n), 0);
    repeat (4) step();
    begin
      int nrd = 0;
      ren_a = 1; ren_b = 1;
      for (int i = 0; i < 30; i++) begin
        if (empty_n) nrd++;
        step();
      end
      chk("R3 words kept", nrd, DEPTH);
      chk("R2 last word", int'(rdata), 'h10F);
      chk("R1 empty after drain", int'(empty_n), 0);
    end
    idle();

    // R4 R5: mixed traffic with threshold changes
    for (int blk = 0; blk < 6; blk++) begin
      case (blk)
        0: begin thr_empty = 5'd0;  thr_full = 5'd0;  end
        1: begin thr_empty = 5'd1;  thr_full = 5'd1;  end
        2: begin thr_empty = 5'd5;  thr_full = 5'd6;  end
        3: begin thr_empty = 5'd15; thr_full = 5'd15; end
        4: begin thr_empty = 5'd16; thr_full = 5'd16; end
        default: begin thr_empty = 5'd3; thr_full = 5'd2; end
      endcase
      for (int c = 0; c < 500; c++) begin
        int bias;
        bias = ((c / 100) % 2 == 0) ? 3 : 1;
        wen_a = ($urandom % 4) < bias;
        wen_b = ($urandom % 8) != 0;
        ren_a = ($urandom % 4) >= bias;
        ren_b = ($urandom % 8) != 0;
        wdata = DW'($urandom);
        step();
      end
    end
    idle();
    repeat (40) begin ren_a = 1; ren_b = 1; step(); end
    chk("R1 empty at end", int'(empty_n), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule